// File: doc/BRIEF.md
# Register-Driven Serial Word Memory Engine

This block models a small serial EEPROM of sixteen-bit words that software operates one pin transition at a time through two host registers: a direction register and a data register. The host never sees a serial clock. Each host write to the data register that carries both enable bits counts as one protocol step. The sequencer walks a start step, a two-bit opcode and a six-bit address, then stays in a transfer phase. In that phase the host streams words in or out one bit per access. The word address advances by itself after each word.

A read command starts with one dummy zero bit. Data bits follow most significant bit first, presented at bit 4 of the value read back. A write command takes one bit per qualifying data write from bit 5 of the written value. A qualifying direction write with the code `2'b10` in bits 5:4 aborts any command in progress. At reset the storage array is loaded with an arithmetic pattern taken from two parameters. Host reads and writes are assumed not to coincide; if they do, the write wins and the read strobe has no effect.

Top module: `bitbang_eeprom`

## Requirements
- R1: A host write with `host_wdata[7:6]` not equal to `2'b11` has no effect on the sequencer, the storage or `pin_dir`, for either register (`host_sel` 0 = data register, 1 = direction register).
- R2: A host write to the direction register with bits 7:6 = `2'b11` loads bits 5:4 into `pin_dir` on the next edge. If those bits are `2'b10`, it also returns the sequencer to its idle state and abandons the command. Any other value leaves the sequencer where it is.
- R3: Qualifying data writes advance the sequencer one step each: idle (command cleared), opcode high bit, opcode low bit, then address bits. In the opcode steps, `host_wdata[5]` gives bits 1 and 0 of the command. Command `2'b10` is a read and `2'b01` is a write; under the other two codes, transfer-phase accesses do nothing and reads return 0.
- R4: The six address steps take the address from `host_wdata[5]`, most significant bit first. After the last one the sequencer is in the transfer phase.
- R5: The first transfer-phase access after an opcode is a dummy. Under a read it returns 0 and under a write it stores nothing; either way the bit position then starts at 0.
- R6: Under a read, each data read returns bit (15 - n) of the addressed word in `host_rdata[4]`, where n is the bit position, and zeros in all other bits. The data read then advances n.
- R7: After bit position 15 the position returns to 0 and the word address increments, wrapping from 63 to 0. This holds for reads and writes alike.
- R8: Under a write, each qualifying data write stores `host_wdata[5]` into bit (15 - n) of the addressed word and advances n.
- R9: A data read outside the transfer phase, or under a non-read command, returns 0 and does not change the sequencer.
- R10: After reset word i holds (i * INIT_MUL + INIT_ADD) mod 2^16, `pin_dir` is 0 and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 1 | Register select: 0 data, 1 direction |
| host_wdata | input | 8 | Host write value |
| host_rd | input | 1 | Host data-register read strobe; the read takes effect at the clock edge |
| host_rdata | output | 8 | Data-register read value, valid before the read strobe's edge |
| pin_dir | output | 2 | Last latched direction field |

## Verification
The bench keeps the default parameters: a 6-bit address, 16-bit words and the default seed pair. With that configuration the whole 64-word array can be streamed in a single read command that runs past word 63 back to word 0. Every bit of every word is checked against values the bench computes from the seed formula. A write stream placed across the 63-to-0 boundary, a noisy address phase, an abort in the middle of a word, and commands that are neither read nor write round out the boundary cases. A final full stream confirms that only the written words changed.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OPHI  = 3'd1,
    ST_OPLO  = 3'd2,
    ST_ADDR  = 3'd3,
    ST_XFER  = 3'd4
  } eep_state_e;

  localparam logic [1:0] CMD_READ  = 2'b10;
  localparam logic [1:0] CMD_WRITE = 2'b01;
  localparam logic [1:0] DIR_ABORT = 2'b10;

  function automatic logic [31:0] seed_word(input int unsigned idx,
                                            input logic [31:0] mul,
                                            input logic [31:0] add);
    return idx * mul + add;
  endfunction

endpackage

// File: rtl/eep_host_qual.sv
module eep_host_qual #(
  parameter int HOST_W  = 8,
  parameter int EN_HI   = 7,
  parameter int EN_LO   = 6,
  parameter int DIN_BIT = 5,
  parameter int DIR_LO  = 4
) (
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  output logic              data_wr_ok,
  output logic              dir_wr_ok,
  output logic              din,
  output logic [1:0]        dir_val
);

  logic enabled;

  always_comb begin
    enabled    = host_wdata[EN_HI] & host_wdata[EN_LO];
    data_wr_ok = host_wr & enabled & ~host_sel;
    dir_wr_ok  = host_wr & enabled & host_sel;
    din        = host_wdata[DIN_BIT];
    dir_val    = host_wdata[DIR_LO+1:DIR_LO];
  end

endmodule

// File: rtl/eep_sequencer.sv
module eep_sequencer
  import eep_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(WORD_W),
  localparam int ACNT_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr_ok,
  input  logic              dir_wr_ok,
  input  logic              din,
  input  logic [1:0]        dir_val,
  input  logic              rd_req,
  output eep_state_e        state,
  output logic [1:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              idx_live,
  output logic              bit_wr_en,
  output logic [1:0]        pin_dir
);

  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(WORD_W - 1);
  localparam logic [ACNT_W-1:0] ACNT_LAST = ACNT_W'(ADDR_W - 1);

  eep_state_e        state_q, state_d;
  logic [1:0]        cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              live_q, live_d;
  logic [1:0]        dir_q, dir_d;
  logic [ACNT_W-1:0] acnt_q, acnt_d;
  logic              xfer_rd, xfer_wr, step;

  always_comb begin
    xfer_rd = (state_q == ST_XFER) && (cmd_q == CMD_READ) && rd_req;
    xfer_wr = (state_q == ST_XFER) && (cmd_q == CMD_WRITE) && data_wr_ok;
    step    = xfer_rd | xfer_wr;
  end

  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    addr_d  = addr_q;
    idx_d   = idx_q;
    live_d  = live_q;
    dir_d   = dir_q;
    acnt_d  = acnt_q;
    if (dir_wr_ok) begin
      dir_d = dir_val;
      if (dir_val == DIR_ABORT) state_d = ST_IDLE;
    end else if (data_wr_ok) begin
      unique case (state_q)
        ST_IDLE: begin
          cmd_d   = 2'b00;
          state_d = ST_OPHI;
        end
        ST_OPHI: begin
          cmd_d[1] = din;
          idx_d    = '0;
          live_d   = 1'b0;
          state_d  = ST_OPLO;
        end
        ST_OPLO: begin
          cmd_d[0] = din;
          acnt_d   = '0;
          state_d  = ST_ADDR;
        end
        ST_ADDR: begin
          addr_d = {addr_q[ADDR_W-2:0], din};
          acnt_d = acnt_q + 1'b1;
          if (acnt_q == ACNT_LAST) state_d = ST_XFER;
        end
        default: ;
      endcase
    end
    if (step) begin
      if (!live_q) begin
        live_d = 1'b1;
        idx_d  = '0;
      end else if (idx_q == IDX_LAST) begin
        idx_d  = '0;
        addr_d = addr_q + 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
      live_q  <= 1'b0;
      dir_q   <= '0;
      acnt_q  <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      idx_q   <= idx_d;
      live_q  <= live_d;
      dir_q   <= dir_d;
      acnt_q  <= acnt_d;
    end
  end

  assign state     = state_q;
  assign cmd       = cmd_q;
  assign addr      = addr_q;
  assign bit_idx   = idx_q;
  assign idx_live  = live_q;
  assign pin_dir   = dir_q;
  assign bit_wr_en = xfer_wr & live_q;

endmodule

// File: rtl/eep_word_array.sv
module eep_word_array
  import eep_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter logic [31:0] INIT_MUL = 32'h0000_9E37,
  parameter logic [31:0] INIT_ADD = 32'h0000_1357,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              wr_bit,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] words [DEPTH];
  logic [WORD_W-1:0] bit_mask;

  always_comb begin
    bit_mask = {{(WORD_W-1){1'b0}}, 1'b1} << (IDX_W'(WORD_W - 1) - bit_idx);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [WORD_W-1:0] word_q, word_d;
    logic              word_en;

    always_comb begin
      word_en = wr_en && (addr == ADDR_W'(i));
      word_d  = wr_bit ? (word_q | bit_mask) : (word_q & ~bit_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= WORD_W'(seed_word(i, INIT_MUL, INIT_ADD));
      end else if (word_en) begin
        word_q <= word_d;
      end
    end

    assign words[i] = word_q;
  end

  assign rd_word = words[addr];

endmodule

// File: rtl/bitbang_eeprom.sv
module bitbang_eeprom
  import eep_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter logic [31:0] INIT_MUL = 32'h0000_9E37,
  parameter logic [31:0] INIT_ADD = 32'h0000_1357,
  parameter int DOUT_BIT = 4,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  input  logic       host_rd,
  output logic [7:0] host_rdata,
  output logic [1:0] pin_dir
);

  logic              data_wr_ok, dir_wr_ok, din;
  logic [1:0]        dir_val;
  logic              rd_req;
  eep_state_e        state;
  logic [1:0]        cmd;
  logic [ADDR_W-1:0] addr;
  logic [IDX_W-1:0]  bit_idx;
  logic              idx_live, bit_wr_en;
  logic [WORD_W-1:0] rd_word;
  logic              out_bit;

  eep_host_qual u_qual (
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .data_wr_ok (data_wr_ok),
    .dir_wr_ok  (dir_wr_ok),
    .din        (din),
    .dir_val    (dir_val)
  );

  assign rd_req = host_rd & ~host_wr;

  eep_sequencer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_wr_ok (data_wr_ok),
    .dir_wr_ok  (dir_wr_ok),
    .din        (din),
    .dir_val    (dir_val),
    .rd_req     (rd_req),
    .state      (state),
    .cmd        (cmd),
    .addr       (addr),
    .bit_idx    (bit_idx),
    .idx_live   (idx_live),
    .bit_wr_en  (bit_wr_en),
    .pin_dir    (pin_dir)
  );

  eep_word_array #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .INIT_MUL(INIT_MUL), .INIT_ADD(INIT_ADD)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bit_wr_en),
    .addr    (addr),
    .bit_idx (bit_idx),
    .wr_bit  (din),
    .rd_word (rd_word)
  );

  always_comb begin
    out_bit    = rd_word[IDX_W'(WORD_W - 1) - bit_idx];
    host_rdata = '0;
    if ((state == ST_XFER) && (cmd == CMD_READ) && idx_live)
      host_rdata[DOUT_BIT] = out_bit;
  end

endmodule

// File: rtl/bitbang_eeprom_chk.sv
module bitbang_eeprom_chk
  import eep_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter int DOUT_BIT = 4,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_sel,
  input logic [7:0]        host_wdata,
  input logic              host_rd,
  input logic [7:0]        host_rdata,
  input logic [1:0]        pin_dir,
  input eep_state_e        state,
  input logic [1:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [IDX_W-1:0]  bit_idx,
  input logic              idx_live
);

  logic rd_xfer;
  assign rd_xfer = host_rd && !host_wr && (state == ST_XFER) && (cmd == CMD_READ);

  AST_UNQUAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (host_wdata[7:6] != 2'b11)) |=>
      ($stable(state) && $stable(cmd) && $stable(addr) && $stable(bit_idx) && $stable(pin_dir))); // R1

  AST_DIR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel && (host_wdata[7:4] == 4'b1110)) |=>
      ((state == ST_IDLE) && (pin_dir == 2'b10))); // R2

  AST_IDLE_CLEARS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_sel && (host_wdata[7:6] == 2'b11) && (state == ST_IDLE)) |=>
      ((state == ST_OPHI) && (cmd == 2'b00))); // R3

  AST_DUMMY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_xfer && !idx_live) |=> (idx_live && (bit_idx == '0))); // R5

  AST_DOUT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_rdata & ~(8'h01 << DOUT_BIT)) == 8'h00)); // R6

  AST_WORD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_xfer && idx_live && (bit_idx == IDX_W'(WORD_W - 1))) |=>
      ((bit_idx == '0) && (addr == ADDR_W'($past(addr) + 1'b1)))); // R7

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != ST_XFER) || (cmd != CMD_READ)) |-> (host_rdata == 8'h00)); // R9

endmodule

bind bitbang_eeprom bitbang_eeprom_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .DOUT_BIT(DOUT_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_sel   (host_sel),
  .host_wdata (host_wdata),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .pin_dir    (pin_dir),
  .state      (state),
  .cmd        (cmd),
  .addr       (addr),
  .bit_idx    (bit_idx),
  .idx_live   (idx_live)
);

// File: tb/bitbang_eeprom_test.sv
module bitbang_eeprom_test;

  localparam int DEPTH = 64;

  logic       clk, rst_n, host_wr, host_sel, host_rd;
  logic [7:0] host_wdata, host_rdata;
  logic [1:0] pin_dir;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [DEPTH];

  bitbang_eeprom uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .pin_dir(pin_dir)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input int got, input int exp, input string req);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic hw(input logic sel, input logic [7:0] val);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = val;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = 8'h00;
  endtask

  task automatic hr(output logic [7:0] val);
    @(negedge clk);
    val = host_rdata;
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic bitw(input logic b);
    hw(1'b0, 8'hC0 | (8'(b) << 5));
  endtask

  task automatic start_cmd(input logic [1:0] c, input logic [5:0] a, input logic noise);
    logic [7:0] v;
    hw(1'b0, 8'hC0);
    bitw(c[1]);
    if (noise) begin
      hr(v);
      check(v, 0, "R9 read during opcode phase");
    end
    bitw(c[0]);
    for (int k = 5; k >= 0; k--) begin
      bitw(a[k]);
      if (noise && k > 0) begin
        hw(1'b0, 8'h3F & ~8'(k[0] << 5));
        hw(1'b0, 8'h60);
        hr(v);
        check(v, 0, "R9 read during address phase");
      end
    end
  endtask

  task automatic stream_check(input int a0, input int nwords, input string req);
    logic [7:0] v;
    for (int w = 0; w < nwords; w++)
      for (int b = 0; b < 16; b++) begin
        hr(v);
        check(v, int'(model[(a0 + w) % DEPTH][15-b]) << 4, req);
      end
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [15:0] pat [3];
    pat[0] = 16'hA5C3; pat[1] = 16'h0F0F; pat[2] = 16'h1234;
    for (int i = 0; i < DEPTH; i++) model[i] = 16'(i * 32'h9E37 + 32'h1357);
    host_wr = 0; host_sel = 0; host_wdata = 0; host_rd = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(host_rdata, 0, "R10 reset read value");
    check(pin_dir, 0, "R10 reset pin_dir");

    hw(1'b1, 8'hF0); check(pin_dir, 3, "R2 direction latch");
    hw(1'b1, 8'h50); check(pin_dir, 3, "R1 unqualified direction write");
    hw(1'b1, 8'hE0); check(pin_dir, 2, "R2 abort code latch");

    // full array read across the 63->0 wrap
    start_cmd(2'b10, 6'd0, 1'b0);
    hr(v); check(v, 0, "R5 dummy read bit");
    stream_check(0, DEPTH + 1, "R6 R7 R10 streamed read");

    // address 45 with noise in address phase
    hw(1'b1, 8'hE0);
    start_cmd(2'b10, 6'd45, 1'b1);
    hr(v); check(v, 0, "R5 dummy after noisy address");
    stream_check(45, 2, "R4 R1 address MSB first");

    // write across wrap 62,63,0
    hw(1'b1, 8'hE0);
    start_cmd(2'b01, 6'd62, 1'b0);
    hr(v); check(v, 0, "R9 read under write command");
    bitw(1'b1);
    for (int w = 0; w < 3; w++)
      for (int b = 0; b < 16; b++) begin
        bitw(pat[w][15-b]);
        if (b == 7) hw(1'b0, 8'h60);
      end
    for (int w = 0; w < 3; w++) model[(62 + w) % DEPTH] = pat[w];
    hw(1'b1, 8'hE0);
    start_cmd(2'b10, 6'd62, 1'b0);
    hr(v); check(v, 0, "R5 dummy before readback");
    stream_check(62, 3, "R8 R7 written words");

    // abort mid-word, then restart
    hw(1'b1, 8'hE0);
    start_cmd(2'b10, 6'd7, 1'b0);
    hr(v);
    stream_check(7, 0, "R6");
    for (int b = 0; b < 5; b++) begin
      hr(v); check(v, int'(model[7][15-b]) << 4, "R6 partial word");
    end
    hw(1'b1, 8'hF0);
    hr(v); check(v, int'(model[7][10]) << 4, "R2 non-abort direction keeps stream");
    hw(1'b1, 8'hE0);
    hr(v); check(v, 0, "R2 read after abort");
    check(pin_dir, 2, "R2 pin_dir after abort");
    start_cmd(2'b10, 6'd7, 1'b0);
    hr(v); check(v, 0, "R5 dummy after restart");
    stream_check(7, 1, "R5 restart from bit 0");

    // non read/write commands
    for (int c = 0; c < 4; c += 3) begin
      hw(1'b1, 8'hE0);
      start_cmd(2'(c), 6'd5, 1'b0);
      for (int k = 0; k < 3; k++) begin
        hw(1'b0, 8'hE0);
        hr(v); check(v, 0, "R3 other command reads zero");
      end
    end

    // final sweep: only written words changed
    hw(1'b1, 8'hE0);
    start_cmd(2'b10, 6'd0, 1'b0);
    hr(v);
    stream_check(0, DEPTH, "R8 R3 final sweep");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule